// File: doc/BRIEF.md
# PLL Phase Lock Monitor

This block reports whether a phase-locked loop has settled. It runs on a fast sampling clock. It receives three inputs: a one-cycle pulse for each reference clock edge, a one-cycle pulse for each feedback (output) clock edge, and the current reference period counted in sampling ticks. The edge pulses must already be synchronized to the sampling clock. For every reference cycle the block measures how far the feedback edge trails the reference edge. It folds that offset into a phase error and compares the error against two windows. The narrow window is a sixteenth of the period (22.5 degrees). The wide window is a quarter of the period (90 degrees).

The lock flag has asymmetric hysteresis. It rises only after a run of consecutive reference cycles that all fall inside the narrow window. Once it is set, it stays set until a single cycle lands outside the wide window. A feedback edge that never arrives inside the reference window counts as a gross phase error. Phase resolution is one sampling tick.

The edge inputs are events, not a data stream. A missed pulse cannot be replayed, so the block takes no valid/ready handshake and never applies back-pressure. Every pulse is consumed in the cycle in which it is presented. The lock output is a plain level.

Top module: `pll_lock_monitor`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears the lock flag and the count of qualifying cycles. The lock flag is low after reset, and a full new qualification run is needed before it can rise.
- R2: Each reference edge opens a window. The tick that carries the reference edge is offset 0. The period used for the window is the ref_period value sampled with that edge. The offset is the tick of the first feedback edge in the window. The phase error is min(offset, period - offset), so offsets close to a full period count as small errors.
- R3: While unlocked, lock goes high after 8 consecutive judged windows that each have 16*error <= period. The flag rises at the clock edge that samples the reference edge closing the eighth such window.
- R4: While unlocked, any judged window with 16*error > period resets the qualification count to zero.
- R5: While locked, a judged window with 4*error > period drops lock at the clock edge that samples the reference edge closing that window. Qualification then starts again from zero.
- R6: While locked, windows with 4*error <= period keep lock high, even when 16*error > period.
- R7: A window with no feedback edge at a tick below its period is judged as an error beyond the wide window. A feedback edge at or after the period tick is not taken.
- R8: The first reference edge after reset only opens a window. No judgment is made until a later reference edge closes it.
- R9: A feedback edge in the same cycle as a reference edge belongs to the new window with offset 0. Feedback edges after the first one in a window are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_edge | input | 1 | One-tick pulse per reference clock edge |
| fb_edge | input | 1 | One-tick pulse per feedback clock edge |
| ref_period | input | PERIOD_W | Reference period in sampling ticks, sampled with ref_edge |
| lock | output | 1 | Lock flag with hysteresis |

## Verification
A window is judged in the cycle that carries its closing reference edge. The lock flag is registered, so it changes at that clock edge and can be observed at the following falling edge. There are no other stages of latency. The bench drives inputs on falling edges. A behavioural model advances at each rising edge from the same inputs, and the flag is compared against the model at every falling edge. The directed checks sit at window boundaries, after the closing reference edge has been sampled, so each expected value counts whole judged windows and no partial ones.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  // Per-window judgment handed from the phase meter to the lock qualifier.
  typedef struct packed {
    logic judge;       // a window closes this cycle
    logic fine_ok;     // error inside the narrow window
    logic coarse_bad;  // error outside the wide window, or no feedback edge
  } phase_verdict_t;
endpackage

// File: rtl/phase_window_meter.sv
module phase_window_meter
  import pll_lock_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ref_edge,
  input  logic           fb_edge,
  input  logic [PW-1:0]  ref_period,
  output phase_verdict_t verdict
);
  localparam logic [PW-1:0] TICK_MAX = '1;
  localparam int            XW       = PW + 4;

  logic [PW-1:0] tick_q, per_q, off_q;
  logic          got_q, armed_q;
  logic [PW-1:0] pos, win_per;
  logic          take;

  // Position inside the current window; the reference-edge tick is zero.
  assign pos     = ref_edge ? '0 : tick_q;
  assign win_per = ref_edge ? ref_period : per_q;
  assign take    = fb_edge && (ref_edge || !got_q) && (pos < win_per);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q  <= '0;
      per_q   <= '0;
      off_q   <= '0;
      got_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (ref_edge) begin
      tick_q  <= PW'(1);
      per_q   <= ref_period;
      armed_q <= 1'b1;
      got_q   <= take;
      off_q   <= '0;
    end else begin
      if (tick_q != TICK_MAX) tick_q <= tick_q + PW'(1);
      if (take) begin
        got_q <= 1'b1;
        off_q <= pos;
      end
    end
  end

  // Fold the offset and compare by scaling the error, so no divider is needed.
  logic [PW-1:0] rest, err;
  logic [XW-1:0] err_x16, err_x4, per_x;

  assign rest    = per_q - off_q;
  assign err     = (off_q <= rest) ? off_q : rest;
  assign err_x16 = {err, 4'b0000};
  assign err_x4  = {2'b00, err, 2'b00};
  assign per_x   = {4'b0000, per_q};

  always_comb begin
    verdict.judge      = ref_edge && armed_q;
    verdict.fine_ok    = got_q && (err_x16 <= per_x);
    verdict.coarse_bad = !got_q || (err_x4 > per_x);
  end

  // R2: a captured offset always lies inside its window.
  a_r2_offset_in_window: assert property (@(posedge clk) disable iff (rst)
    got_q |-> (off_q < per_q));

  // R9: a feedback edge that coincides with a reference edge opens the new window at offset 0.
  a_r9_coincident_zero: assert property (@(posedge clk) disable iff (rst)
    (ref_edge && fb_edge && (ref_period != '0)) |=> (got_q && off_q == '0));

  // R8: nothing is judged in the cycle after reset releases.
  a_r8_no_judge_first: assert property (@(posedge clk)
    rst |=> !armed_q);
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import pll_lock_pkg::*;
#(
  parameter int QUAL_N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  phase_verdict_t verdict,
  output logic           lock
);
  localparam int QW = $clog2(QUAL_N + 1);
  localparam logic [QW-1:0] LAST = QW'(QUAL_N - 1);

  logic [QW-1:0] qual_q;
  logic          lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      qual_q <= '0;
    end else if (verdict.judge) begin
      if (lock_q) begin
        if (verdict.coarse_bad) begin
          lock_q <= 1'b0;
          qual_q <= '0;
        end
      end else if (verdict.fine_ok) begin
        if (qual_q == LAST) begin
          lock_q <= 1'b1;
          qual_q <= '0;
        end else begin
          qual_q <= qual_q + QW'(1);
        end
      end else begin
        qual_q <= '0;
      end
    end
  end

  assign lock = lock_q;

  // R1: reset always leaves the flag low and the count cleared.
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!lock_q && qual_q == '0));

  // R5: a gross error while locked drops the flag at once.
  a_r5_drop_on_coarse: assert property (@(posedge clk) disable iff (rst)
    (verdict.judge && lock_q && verdict.coarse_bad) |=> !lock_q);

  // R6: with no judgment made, a held lock persists.
  a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !verdict.judge) |=> lock_q);

  // R3: a rising flag follows a judged fine window.
  a_r3_rise_after_fine: assert property (@(posedge clk) disable iff (rst)
    (!lock_q && !(verdict.judge && verdict.fine_ok)) |=> !lock_q);

  // R4: a window outside the narrow band clears qualification progress.
  a_r4_count_clears: assert property (@(posedge clk) disable iff (rst)
    (verdict.judge && !lock_q && !verdict.fine_ok) |=> (qual_q == '0 && !lock_q));
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import pll_lock_pkg::*;
#(
  parameter int PERIOD_W    = 16,
  parameter int QUAL_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_edge,
  input  logic                fb_edge,
  input  logic [PERIOD_W-1:0] ref_period,
  output logic                lock
);
  phase_verdict_t verdict;

  phase_window_meter #(.PW(PERIOD_W)) u_meter (
    .clk        (clk),
    .rst        (rst),
    .ref_edge   (ref_edge),
    .fb_edge    (fb_edge),
    .ref_period (ref_period),
    .verdict    (verdict)
  );

  lock_qualifier #(.QUAL_N(QUAL_CYCLES)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .verdict (verdict),
    .lock    (lock)
  );
endmodule

// File: tb/tb_pll_lock_monitor.sv
module tb_pll_lock_monitor;
  localparam int PW = 16;
  localparam int P  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_edge = 1'b0;
  logic          fb_edge = 1'b0;
  logic [PW-1:0] ref_period = PW'(P);
  logic          lock;

  int checks = 0;
  int errors = 0;
  string phase_req = "R1";
  bit done = 1'b0;

  pll_lock_monitor #(.PERIOD_W(PW), .QUAL_CYCLES(8)) dut (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .ref_period(ref_period), .lock(lock)
  );

  always #10 clk = ~clk;

  // Behavioural reference model, advanced on each rising edge.
  int  m_tick = 0, m_per = 0, m_off = 0, m_qual = 0;
  bit  m_got = 0, m_armed = 0, m_lock = 0;
  int  v_pos, v_wper, v_err;
  bit  v_take, v_good, v_bad;

  always @(posedge clk) begin
    if (rst) begin
      m_tick = 0; m_per = 0; m_off = 0; m_qual = 0;
      m_got = 0; m_armed = 0; m_lock = 0;
    end else begin
      v_pos  = ref_edge ? 0 : m_tick;
      v_wper = ref_edge ? int'(ref_period) : m_per;
      v_take = fb_edge && (ref_edge || !m_got) && (v_pos < v_wper);
      if (ref_edge && m_armed) begin
        v_err  = (m_off <= m_per - m_off) ? m_off : m_per - m_off;
        v_good = m_got && (16 * v_err <= m_per);
        v_bad  = !m_got || (4 * v_err > m_per);
        if (m_lock) begin
          if (v_bad) begin m_lock = 0; m_qual = 0; end
        end else if (v_good) begin
          m_qual++;
          if (m_qual == 8) begin m_lock = 1; m_qual = 0; end
        end else m_qual = 0;
      end
      if (ref_edge) begin
        m_tick = 1; m_per = int'(ref_period); m_armed = 1;
        m_got = v_take; m_off = 0;
      end else begin
        m_tick++;
        if (v_take) begin m_got = 1; m_off = v_pos; end
      end
    end
  end

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (lock !== m_lock) begin
        errors++;
        $display("FAIL %s per-clock lock actual=%b expected=%b t=%0t", phase_req, lock, m_lock, $time);
      end
    end
  end

  task automatic chk(input bit exp, input string req);
    checks++;
    if (lock !== exp) begin
      errors++;
      $display("FAIL %s directed lock actual=%b expected=%b t=%0t", req, lock, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ref_edge = 1'b0; fb_edge = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // One reference window of P ticks; feedback pulses at off_a and off_b (-1 means none).
  task automatic window(input int off_a, input int off_b);
    for (int t = 0; t < P; t++) begin
      ref_edge = (t == 0);
      fb_edge  = (t == off_a) || (t == off_b);
      @(negedge clk);
    end
    ref_edge = 1'b0; fb_edge = 1'b0;
  endtask

  task automatic windows(input int n, input int off_a);
    for (int i = 0; i < n; i++) window(off_a, -1);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    phase_req = "R1"; chk(1'b0, "R1");

    // R3 and R8: eight good windows give only seven judgments; the ninth edge sets lock.
    phase_req = "R3"; do_reset();
    windows(8, 1); chk(1'b0, "R8");
    window(2, -1); chk(1'b1, "R3");

    // R4 with R2 folding: offset 30 folds to error 2 (good); offset 3 is error 3 (not good).
    phase_req = "R4"; do_reset();
    windows(6, 30); window(3, -1); windows(8, 30); chk(1'b0, "R4");
    window(30, -1); chk(1'b1, "R2");

    // R6: errors of 8 (direct and folded from 24) keep lock.
    phase_req = "R6";
    windows(2, 8); window(24, -1); window(1, -1); chk(1'b1, "R6");

    // R5: error 9 drops lock; qualification restarts.
    phase_req = "R5";
    window(9, -1); window(1, -1); chk(1'b0, "R5");
    windows(7, 2); chk(1'b0, "R5");
    window(2, -1); chk(1'b1, "R5");

    // R7: window without feedback drops lock.
    phase_req = "R7";
    window(-1, -1); window(1, -1); chk(1'b0, "R7");

    // R9: coincident feedback is offset 0; extra mid-window feedback ignored.
    phase_req = "R9"; do_reset();
    for (int i = 0; i < 9; i++) window(0, 16);
    chk(1'b1, "R9");

    // R1: reset during qualification clears progress.
    phase_req = "R1"; do_reset();
    windows(5, 1); do_reset(); chk(1'b0, "R1");
    windows(8, 1); chk(1'b0, "R1");
    window(1, -1); chk(1'b1, "R1");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule